// File: doc/BRIEF.md
# Dual-Bank Synchronous Burst SRAM

A behavioural, synthesizable model of a flow-through synchronous burst memory built from two banks that share one address bus, one set of burst strobes and one tri-state 72-bit data bus. Each bus word is 64 data bits plus 8 parity bits. All of these are stored together. On every rising clock edge the block samples the address, the two active-low bank enables, the active-low global write and three strobes. The two load strobes are a read-only load and a general load. The third strobe steps or holds the burst address. From these inputs the block decides whether to deselect, start a burst, continue a burst or suspend a burst.

A three-state machine tracks the active burst. Its states are `S_IDLE` (deselected), `S_READ` and `S_WRITE`. The transitions are as follows:
- Any load moves the machine to `S_READ` or `S_WRITE`.
- A general load with neither bank enabled moves it to `S_IDLE`.
- A continue or a suspend keeps the current bank. It picks `S_READ` or `S_WRITE` from global write.
- A continue or a suspend seen in `S_IDLE` is a no-op, and the machine stays in `S_IDLE`.

Read data is combinational from the registered address. It therefore appears during the cycle that follows the capturing edge. Write data is taken from the bus on the edge that carries the write command. An asynchronous active-low output enable gates the bus drivers. Each bank also has an asynchronous sleep input that freezes that bank.

Top module: `sbsram_dual`

## Requirements
- R1: After reset the machine is in `S_IDLE`, the bus `dq` is high-impedance and `proto_err` is 0.
- R2: A general load (`load_n`=0) with both `en_a_n` and `en_b_n` high deselects the block. The bus is high-impedance in the next cycle. Later continue or suspend cycles leave it idle and undriven.
- R3: A read-only load (`load_rd_n`=0 with at least one enable low) registers `addr` and starts a read in the enabled bank. `gw_n` is ignored, so nothing is written.
- R4: A general load with `load_rd_n` high and one enable low registers `addr`. With `gw_n`=0 it writes the full 72-bit bus word at that address on that edge. With `gw_n`=1 it starts a read.
- R5: With both load strobes high and `step_n`=0 outside `S_IDLE`, the burst continues at the next address. The next address adds 1 modulo 4 to the low two address bits and keeps the upper bits, so 0x0B is followed by 0x08 and then 0x09. The cycle is a write when `gw_n`=0 and a read otherwise.
- R6: With both load strobes high and `step_n`=1 outside `S_IDLE`, the burst is suspended. The same address and bank are used again.
- R7: `oe_n` is active-low and asynchronous. While it is 1 the bus is high-impedance even in `S_READ`. Changing it takes effect without a clock edge.
- R8: Read data is flow-through. The word at a registered address is on `dq` in the same cycle that follows the edge that captured the address.
- R9: While `sleep_a` (or `sleep_b`) is 1, that bank is never written and never drives the bus. The effect starts and ends without a clock edge.
- R10: A load with both enables low selects bank A. That load is carried out in bank A only, and `proto_err` rises and stays at 1 until reset.
- R11: With `load_n` held low and `load_rd_n`/`step_n` high, every cycle is an independent single read or write at the external address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | AW | Word address within a bank |
| en_a_n | input | 1 | Active-low enable, bank A |
| en_b_n | input | 1 | Active-low enable, bank B |
| gw_n | input | 1 | Active-low global (full word) write |
| load_rd_n | input | 1 | Active-low read-only load strobe |
| load_n | input | 1 | Active-low general load strobe |
| step_n | input | 1 | Active-low burst step (high = suspend) |
| oe_n | input | 1 | Active-low asynchronous output enable |
| sleep_a | input | 1 | Active-high asynchronous sleep, bank A |
| sleep_b | input | 1 | Active-high asynchronous sleep, bank B |
| dq | inout | DATA_W+PAR_W | Shared data and parity bus |
| proto_err | output | 1 | Sticky flag: both enables low on a load |

## Verification
In some cycles two of the block's functions overlap. In one, a read is in progress in `S_READ` while an asynchronous gate, either output enable or bank sleep, changes between clock edges. The bench provokes this by toggling `oe_n` and `sleep_a` a nanosecond after an edge. It judges the bus both before and after the toggle, without clocking. In the other, the bench asserts both bank enables during a write load. It checks that bank A took the word, that bank B kept its earlier contents, and that `proto_err` stays set through later normal traffic.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_READ  = 2'd1,
        S_WRITE = 2'd2
    } state_e;

    typedef enum logic [2:0] {
        CMD_NOP     = 3'd0,
        CMD_DESEL   = 3'd1,
        CMD_LOAD_RD = 3'd2,
        CMD_LOAD    = 3'd3,
        CMD_CONT    = 3'd4,
        CMD_HOLD    = 3'd5
    } cmd_e;

    localparam int NUM_BANKS = 2;

endpackage

// File: rtl/sbsram_cmd_decode.sv
module sbsram_cmd_decode
    import sbsram_pkg::*;
(
    input  logic load_rd_n,
    input  logic load_n,
    input  logic step_n,
    input  logic en_a_n,
    input  logic en_b_n,
    input  logic active,
    output cmd_e cmd,
    output logic pick_b,
    output logic clash
);

    logic any_en;

    assign any_en = !en_a_n || !en_b_n;

    always_comb begin
        if (!load_rd_n && any_en) begin
            cmd = CMD_LOAD_RD;
        end else if (!load_n) begin
            cmd = any_en ? CMD_LOAD : CMD_DESEL;
        end else if (active) begin
            cmd = step_n ? CMD_HOLD : CMD_CONT;
        end else begin
            cmd = CMD_NOP;
        end
    end

    // Bank A wins whenever its enable is low.
    assign pick_b = en_a_n;
    assign clash  = ((cmd == CMD_LOAD_RD) || (cmd == CMD_LOAD)) && !en_a_n && !en_b_n;

endmodule

// File: rtl/sbsram_bank.sv
module sbsram_bank #(
    parameter int AW     = 6,
    parameter int WORD_W = 72
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              sleep,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // R9: a sleeping bank is never written
    p_sleep_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !we);

endmodule

// File: rtl/sbsram_dual.sv
module sbsram_dual
    import sbsram_pkg::*;
#(
    parameter int AW     = 6,
    parameter int DATA_W = 64,
    parameter int PAR_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           addr,
    input  logic                    en_a_n,
    input  logic                    en_b_n,
    input  logic                    gw_n,
    input  logic                    load_rd_n,
    input  logic                    load_n,
    input  logic                    step_n,
    input  logic                    oe_n,
    input  logic                    sleep_a,
    input  logic                    sleep_b,
    inout  wire [DATA_W+PAR_W-1:0]  dq,
    output logic                    proto_err
);

    localparam int WORD_W = DATA_W + PAR_W;

    state_e            state_q, state_n;
    logic [AW-1:0]     addr_q, addr_n;
    logic              bank_q, bank_n;
    logic              err_q;

    cmd_e              cmd;
    logic              pick_b;
    logic              clash;
    logic              wr_now;
    logic              drive;
    logic [WORD_W-1:0] rd_word;

    logic              sleep_v [NUM_BANKS];
    logic              we_v    [NUM_BANKS];
    logic [WORD_W-1:0] rdata_v [NUM_BANKS];

    assign sleep_v[0] = sleep_a;
    assign sleep_v[1] = sleep_b;

    sbsram_cmd_decode u_dec (
        .load_rd_n (load_rd_n),
        .load_n    (load_n),
        .step_n    (step_n),
        .en_a_n    (en_a_n),
        .en_b_n    (en_b_n),
        .active    (state_q != S_IDLE),
        .cmd       (cmd),
        .pick_b    (pick_b),
        .clash     (clash)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            addr_q  <= '0;
            bank_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            addr_q  <= addr_n;
            bank_q  <= bank_n;
            err_q   <= err_q | clash;
        end
    end

    // Next state, address and bank
    always_comb begin
        state_n = state_q;
        addr_n  = addr_q;
        bank_n  = bank_q;
        wr_now  = 1'b0;
        unique case (cmd)
            CMD_NOP: begin
                state_n = state_q;
            end
            CMD_DESEL: begin
                state_n = S_IDLE;
            end
            CMD_LOAD_RD: begin
                state_n = S_READ;
                addr_n  = addr;
                bank_n  = pick_b;
            end
            CMD_LOAD: begin
                state_n = gw_n ? S_READ : S_WRITE;
                addr_n  = addr;
                bank_n  = pick_b;
                wr_now  = !gw_n;
            end
            CMD_CONT: begin
                state_n = gw_n ? S_READ : S_WRITE;
                addr_n  = {addr_q[AW-1:2], addr_q[1:0] + 2'd1};
                wr_now  = !gw_n;
            end
            CMD_HOLD: begin
                state_n = gw_n ? S_READ : S_WRITE;
                wr_now  = !gw_n;
            end
            default: begin
                state_n = state_q;
            end
        endcase
    end

    genvar gb;
    generate
        for (gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
            assign we_v[gb] = wr_now && (bank_n == gb[0]) && !sleep_v[gb];
            sbsram_bank #(
                .AW     (AW),
                .WORD_W (WORD_W)
            ) u_bank (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (we_v[gb]),
                .sleep (sleep_v[gb]),
                .waddr (addr_n),
                .wdata (dq),
                .raddr (addr_q),
                .rdata (rdata_v[gb])
            );
        end
    endgenerate

    // Outputs: flow-through read, asynchronous gating
    always_comb begin
        rd_word = bank_q ? rdata_v[1] : rdata_v[0];
        unique case (state_q)
            S_READ:  drive = !oe_n && !(bank_q ? sleep_b : sleep_a);
            S_WRITE: drive = 1'b0;
            S_IDLE:  drive = 1'b0;
            default: drive = 1'b0;
        endcase
    end

    assign dq        = drive ? rd_word : {WORD_W{1'bz}};
    assign proto_err = err_q;

    // R2: general load with no bank enabled deselects
    p_desel_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && en_a_n && en_b_n) |=> (state_q == S_IDLE));

    // R3: read-only load always begins a read
    p_rdload_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_rd_n && (!en_a_n || !en_b_n)) |=> (state_q == S_READ));

    // R5: continue steps the low bits and keeps the upper bits
    p_cont_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != S_IDLE) && load_rd_n && load_n && !step_n)
        |=> ((addr_q[1:0] == $past(addr_q[1:0]) + 2'd1) && $stable(addr_q[AW-1:2])));

    // R6: suspend reuses address and bank
    p_hold_still_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != S_IDLE) && load_rd_n && load_n && step_n)
        |=> ($stable(addr_q) && $stable(bank_q)));

    // R10: clash picks bank A and the flag never falls
    p_clash_bank_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && !en_a_n && !en_b_n) |=> (bank_q == 1'b0));

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

endmodule

// File: tb/sbsram_dual_test.sv
`timescale 1ns/1ps
module sbsram_dual_test;

    localparam int AW = 6;
    localparam int WW = 72;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          en_a_n = 1'b1, en_b_n = 1'b1, gw_n = 1'b1;
    logic          load_rd_n = 1'b1, load_n = 1'b1, step_n = 1'b1;
    logic          oe_n = 1'b0, sleep_a = 1'b0, sleep_b = 1'b0;
    logic          tb_drive = 1'b0;
    logic [WW-1:0] tb_word = '0;
    wire  [WW-1:0] dq;
    logic          proto_err;

    int checks = 0;
    int errors = 0;

    localparam logic [WW-1:0] ZZ = {WW{1'bz}};
    localparam logic [WW-1:0] W1 = 72'hA1_0123_4567_89AB_CDEF;
    localparam logic [WW-1:0] W2 = 72'h5C_FEDC_BA98_7654_3210;
    localparam logic [WW-1:0] W3 = 72'h3E_1111_2222_3333_4444;
    localparam logic [WW-1:0] W4 = 72'hF0_DEAD_BEEF_0000_FFFF;
    localparam logic [WW-1:0] W5 = 72'h0F_CAFE_F00D_1234_5678;
    localparam logic [WW-1:0] D0 = 72'h81_0000_0000_0000_00D0;
    localparam logic [WW-1:0] D1 = 72'h42_0000_0000_0000_00D1;
    localparam logic [WW-1:0] D2 = 72'h24_0000_0000_0000_00D2;
    localparam logic [WW-1:0] JK = 72'hFF_FFFF_FFFF_FFFF_FFFF;

    assign dq = tb_drive ? tb_word : ZZ;

    always #4 clk = ~clk;

    sbsram_dual #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .en_a_n(en_a_n), .en_b_n(en_b_n), .gw_n(gw_n),
        .load_rd_n(load_rd_n), .load_n(load_n), .step_n(step_n),
        .oe_n(oe_n), .sleep_a(sleep_a), .sleep_b(sleep_b),
        .dq(dq), .proto_err(proto_err)
    );

    task automatic chk(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        load_rd_n = 1'b1; load_n = 1'b1; step_n = 1'b1; gw_n = 1'b1;
        en_a_n = 1'b1; en_b_n = 1'b1; oe_n = 1'b0; tb_drive = 1'b0;
    endtask

    task automatic sel(input bit b);
        en_a_n = b;
        en_b_n = !b;
    endtask

    task automatic sync_wr(input bit b, input logic [AW-1:0] a, input logic [WW-1:0] d);
        load_n = 1'b0; sel(b); gw_n = 1'b0; oe_n = 1'b1;
        tb_drive = 1'b1; tb_word = d; addr = a;
        tick();
        quiet();
    endtask

    task automatic sync_rd(input bit b, input logic [AW-1:0] a, output logic [WW-1:0] d);
        load_n = 1'b0; sel(b); gw_n = 1'b1; oe_n = 1'b0; tb_drive = 1'b0; addr = a;
        tick();
        d = dq;
        quiet();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 bus idle after reset", dq, ZZ);
        chk("R1 error flag clear", {71'd0, proto_err}, 72'd0);
    endtask

    task automatic t_sync_mode();
        logic [WW-1:0] r;
        sync_wr(1'b0, 6'd5, W1);
        sync_wr(1'b0, 6'd6, W2);
        sync_wr(1'b1, 6'd5, W3);
        sync_rd(1'b0, 6'd5, r); chk("R8 R11 flow-through read A5", r, W1);
        sync_rd(1'b0, 6'd6, r); chk("R4 R11 read A6", r, W2);
        sync_rd(1'b1, 6'd5, r); chk("R11 read B5", r, W3);
        sync_rd(1'b0, 6'd5, r); chk("R11 A5 kept apart from B5", r, W1);
    endtask

    task automatic t_deselect();
        load_n = 1'b0; en_a_n = 1'b1; en_b_n = 1'b1; oe_n = 1'b0;
        tick();
        chk("R2 deselect floats bus", dq, ZZ);
        load_n = 1'b1; step_n = 1'b0;
        tick();
        chk("R2 continue while idle stays undriven", dq, ZZ);
        quiet();
    endtask

    task automatic t_rd_load();
        logic [WW-1:0] r;
        load_rd_n = 1'b0; sel(1'b0); gw_n = 1'b0; oe_n = 1'b0; addr = 6'd6;
        tick();
        chk("R3 read-only load ignores write strobe", dq, W2);
        quiet();
        sync_rd(1'b0, 6'd6, r); chk("R3 word unchanged", r, W2);
    endtask

    task automatic t_burst();
        logic [WW-1:0] r;
        load_n = 1'b0; sel(1'b0); gw_n = 1'b0; oe_n = 1'b1;
        tb_drive = 1'b1; tb_word = D0; addr = 6'h0B;
        tick();
        load_n = 1'b1; en_a_n = 1'b1; step_n = 1'b0; tb_word = D1;
        tick();
        tb_word = D2;
        tick();
        quiet();
        sync_rd(1'b0, 6'h0B, r); chk("R4 burst first word", r, D0);
        sync_rd(1'b0, 6'h08, r); chk("R5 burst wrap to 08", r, D1);
        sync_rd(1'b0, 6'h09, r); chk("R5 burst third word 09", r, D2);
        // burst read
        load_n = 1'b0; sel(1'b0); gw_n = 1'b1; oe_n = 1'b0; addr = 6'h0B;
        tick();
        chk("R4 read burst start", dq, D0);
        load_n = 1'b1; en_a_n = 1'b1; step_n = 1'b0;
        tick();
        chk("R5 read continue wraps", dq, D1);
        step_n = 1'b1;
        tick();
        chk("R6 suspend keeps address", dq, D1);
        oe_n = 1'b1; #1;
        chk("R7 output enable high floats bus", dq, ZZ);
        oe_n = 1'b0; #1;
        chk("R7 output enable low drives again", dq, D1);
        step_n = 1'b0;
        tick();
        chk("R5 continue after suspend", dq, D2);
        quiet();
    endtask

    task automatic t_sleep();
        logic [WW-1:0] r;
        sleep_a = 1'b1;
        load_n = 1'b0; sel(1'b0); gw_n = 1'b1; oe_n = 1'b0; addr = 6'd5;
        tick();
        chk("R9 sleeping bank does not drive", dq, ZZ);
        quiet();
        sleep_a = 1'b0; #1;
        chk("R9 wake drives without clock", dq, W1);
        sleep_a = 1'b1;
        sync_wr(1'b0, 6'd5, JK);
        sleep_a = 1'b0;
        sync_rd(1'b0, 6'd5, r); chk("R9 write to sleeping bank ignored", r, W1);
    endtask

    task automatic t_clash();
        logic [WW-1:0] r;
        sync_wr(1'b1, 6'd7, W5);
        load_n = 1'b0; en_a_n = 1'b0; en_b_n = 1'b0; gw_n = 1'b0; oe_n = 1'b1;
        tb_drive = 1'b1; tb_word = W4; addr = 6'd7;
        tick();
        quiet();
        chk("R10 error flag raised", {71'd0, proto_err}, 72'd1);
        sync_rd(1'b0, 6'd7, r); chk("R10 bank A took word", r, W4);
        sync_rd(1'b1, 6'd7, r); chk("R10 bank B untouched", r, W5);
        chk("R10 error flag sticky", {71'd0, proto_err}, 72'd1);
    endtask

    initial begin
        quiet();
        t_reset();
        t_sync_mode();
        t_deselect();
        t_rd_load();
        t_burst();
        t_sleep();
        t_clash();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule